// File: doc/BRIEF.md
# Deblocking Sample Filter Datapath

This block produces the filtered samples on both sides of one block edge that is four rows long. Each row carries four samples on the near side (p0 nearest the edge, out to p3) and four on the far side (q0 out to q3). With the block, the caller supplies the clipping bound tc, the boundary strength and the filter choice made by an upstream decision unit. The block returns p0..p2 and q0..q2 for every row. For each sample, a multiplexer chooses either the original value or the filtered one.

Three filters are built in. The normal luma filter moves the two samples next to the edge by a clipped delta. It can also move the second sample on each side by a delta that is always computed, then used or dropped under its own enable, and a per-row size check can cancel it. The strong luma filter replaces three samples on each side with weighted averages. The chroma filter moves only the sample next to the edge on each side. All arithmetic uses shifts and adds, and every result saturates to the sample range.

Two copies of the row datapath run side by side. A captured edge therefore leaves the block as two output beats of two rows each: rows 0 and 1 first, then rows 2 and 3. A new edge can be accepted every two cycles.

Top module: `dbf_sample_filter`

## Requirements
- R1: While reset is held and right after it, outValid is 0, outHalf is 0 and outRows is all zeros.
- R2: A start sampled high at a clock edge, while the block is idle or is producing its second beat, captures blkIn, tc, bs, mode, p1En and q1En. The beat with rows 0 and 1 appears after the next edge (outValid=1, outHalf=0). The beat with rows 2 and 3 appears after the edge that follows (outValid=1, outHalf=1). In blkIn, row r sample k lies at bits [(8r+k)*8 +: 8], where k=0..3 is p0..p3 and k=4..7 is q0..q3. In outRows, lane l sample j lies at bits [(6l+j)*8 +: 8], where j=0..2 is p0..p2 and j=3..5 is q0..q2.
- R3: In normal mode (mode=1) with bs nonzero, a row that passes the check of R5 gets p0+d0 and q0-d0. Here d0 = clip(±tc, (9(q0-p0) - 3(q1-p1) + 8) >> 4), where the shift is arithmetic and rounds toward minus infinity. Every final sample saturates to 0..255.
- R4: In normal mode, p1 becomes p1 + clip(±(tc>>1), ((((p2+p0+1)>>1) - p1 + d0) >> 1)) only when p1En=1. q1 becomes q1 - clip(±(tc>>1), ((((q2+q0+1)>>1) - q1 - d0) >> 1)) only when q1En=1. With an enable at 0, the sample on that side leaves the block unchanged.
- R5: In normal mode, a row whose unclipped delta satisfies |(9(q0-p0) - 3(q1-p1) + 8) >> 4| >= 10·tc leaves the block with all six samples unchanged. Other rows of the same edge are still filtered.
- R6: In strong mode (mode=2) with bs nonzero, all four rows are filtered. The results are p0'=(p2+2p1+2p0+2q0+q1+4)>>3, p1'=(p2+p1+p0+q0+2)>>2, p2'=(2p3+3p2+p1+p0+q0+4)>>3, and the mirror images on the q side. Each result is clipped to within ±2·tc of the original sample. In every mode, no output sample differs from its input by more than 2·tc.
- R7: In chroma mode (mode=3), filtering happens only when bs equals 2. Then p0 becomes p0+dc and q0 becomes q0-dc, where dc = clip(±tc, (4(q0-p0) + p1 - q1 + 4) >> 3). All other samples are unchanged.
- R8: Every sample leaves the block unchanged when mode is 0, when mode is 1 or 2 with bs=0, or when mode is 3 with bs other than 2. p2 and q2 change only in strong mode.
- R9: A start sampled at the edge right after an accepted start is ignored. The two beats of the first edge appear unchanged, and no extra beat follows them.
- R10: While outValid is 0, outRows and outHalf hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture request for a new edge |
| blkIn | input | 256 | Four rows of eight samples each |
| tc | input | 5 | Clipping bound |
| bs | input | 2 | Boundary strength |
| mode | input | 2 | 0 none, 1 normal luma, 2 strong luma, 3 chroma |
| p1En | input | 1 | Normal mode: allow the second p-side sample to change |
| q1En | input | 1 | Normal mode: allow the second q-side sample to change |
| outValid | output | 1 | An output beat is present |
| outHalf | output | 1 | 0 for rows 0-1, 1 for rows 2-3 |
| outRows | output | 96 | Two rows of six samples each |

## Verification
Only one register stage separates the captured edge from the output. If start is sampled at edge E0, the beat with rows 0 and 1 is due after edge E1 and the beat with rows 2 and 3 after E2. The bench drives start on a falling edge and reads each beat on the falling edge that follows E1 and E2. For an edge accepted back to back during the second beat, it shifts this schedule by two cycles. For each row, the expected samples come from an integer model built from the formulas in the requirements. The bench also checks a few hand-worked values: saturation at both ends of the range, and the strong clip. The assertions apply the same timing with fixed depths of two and three cycles.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_STRONG = 2'd2,
    MODE_CHROMA = 2'd3
  } filt_mode_e;

  typedef struct packed {
    logic capture;
    logic emit;
  } dbf_strobe_t;

endpackage

// File: rtl/dbf_row_filter.sv
module dbf_row_filter
  import dbf_pkg::*;
#(
  parameter int SW   = 8,
  parameter int TC_W = 5
) (
  input  logic [4*SW-1:0] pIn,
  input  logic [4*SW-1:0] qIn,
  input  logic [TC_W-1:0] tc,
  input  logic [1:0]      bs,
  input  filt_mode_e      mode,
  input  logic            p1En,
  input  logic            q1En,
  output logic [3*SW-1:0] pOut,
  output logic [3*SW-1:0] qOut
);
  localparam int W = SW + TC_W + 3;
  typedef logic signed [W-1:0] sval_t;
  localparam sval_t MAXV = sval_t'((1 << SW) - 1);
  localparam sval_t K1 = sval_t'(1);
  localparam sval_t K2 = sval_t'(2);
  localparam sval_t K4 = sval_t'(4);
  localparam sval_t K8 = sval_t'(8);

  function automatic sval_t ext(input logic [SW-1:0] v);
    return sval_t'({{(W-SW){1'b0}}, v});
  endfunction

  function automatic sval_t clip(input sval_t lo, input sval_t hi, input sval_t x);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  function automatic logic [SW-1:0] sat(input sval_t x);
    if (x < 0) return '0;
    if (x > MAXV) return '1;
    return x[SW-1:0];
  endfunction

  sval_t p [4];
  sval_t q [4];
  sval_t tcS, tcH, tc2, tc10;
  sval_t diff, diff9, edge3, d0Raw, d0Abs, d0, dp1, dq1, dc;
  sval_t sp [3];
  sval_t sq [3];
  logic  rowOk;
  logic [SW-1:0] po [3];
  logic [SW-1:0] qo [3];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      p[k] = ext(pIn[k*SW +: SW]);
      q[k] = ext(qIn[k*SW +: SW]);
    end
    tcS  = sval_t'({{(W-TC_W){1'b0}}, tc});
    tcH  = tcS >>> 1;
    tc2  = tcS <<< 1;
    tc10 = (tcS <<< 3) + (tcS <<< 1);

    // normal filter: first delta, its veto, and the second-sample deltas
    diff  = q[0] - p[0];
    diff9 = (diff <<< 3) + diff;
    edge3 = ((q[1] - p[1]) <<< 1) + (q[1] - p[1]);
    d0Raw = (diff9 - edge3 + K8) >>> 4;
    d0Abs = (d0Raw < 0) ? -d0Raw : d0Raw;
    rowOk = d0Abs < tc10;
    d0    = clip(-tcS, tcS, d0Raw);
    dp1   = clip(-tcH, tcH, ((((p[2] + p[0] + K1) >>> 1) - p[1] + d0) >>> 1));
    dq1   = clip(-tcH, tcH, ((((q[2] + q[0] + K1) >>> 1) - q[1] - d0) >>> 1));

    // strong filter weighted averages
    sp[0] = (p[2] + (p[1] <<< 1) + (p[0] <<< 1) + (q[0] <<< 1) + q[1] + K4) >>> 3;
    sp[1] = (p[2] + p[1] + p[0] + q[0] + K2) >>> 2;
    sp[2] = ((p[3] <<< 1) + (p[2] <<< 1) + p[2] + p[1] + p[0] + q[0] + K4) >>> 3;
    sq[0] = (p[1] + (p[0] <<< 1) + (q[0] <<< 1) + (q[1] <<< 1) + q[2] + K4) >>> 3;
    sq[1] = (p[0] + q[0] + q[1] + q[2] + K2) >>> 2;
    sq[2] = ((q[3] <<< 1) + (q[2] <<< 1) + q[2] + q[1] + q[0] + p[0] + K4) >>> 3;

    // chroma delta
    dc = clip(-tcS, tcS, ((diff <<< 2) + p[1] - q[1] + K4) >>> 3);

    // per-sample output select
    for (int j = 0; j < 3; j++) begin
      po[j] = pIn[j*SW +: SW];
      qo[j] = qIn[j*SW +: SW];
    end
    unique case (mode)
      MODE_NORMAL: if (bs != 2'd0 && rowOk) begin
        po[0] = sat(p[0] + d0);
        qo[0] = sat(q[0] - d0);
        if (p1En) po[1] = sat(p[1] + dp1);
        if (q1En) qo[1] = sat(q[1] - dq1);
      end
      MODE_STRONG: if (bs != 2'd0) begin
        for (int j = 0; j < 3; j++) begin
          po[j] = sat(clip(p[j] - tc2, p[j] + tc2, sp[j]));
          qo[j] = sat(clip(q[j] - tc2, q[j] + tc2, sq[j]));
        end
      end
      MODE_CHROMA: if (bs == 2'd2) begin
        po[0] = sat(p[0] + dc);
        qo[0] = sat(q[0] - dc);
      end
      default: ;
    endcase
  end

  for (genvar j = 0; j < 3; j++) begin : g_pack
    assign pOut[j*SW +: SW] = po[j];
    assign qOut[j*SW +: SW] = qo[j];
  end

endmodule

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
  import dbf_pkg::*;
#(
  parameter int HALVES = 2,
  parameter int HALF_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output dbf_strobe_t       strobe,
  output logic [HALF_W-1:0] halfSel
);
  localparam logic [HALF_W-1:0] LAST = HALF_W'(HALVES - 1);

  logic busy;
  logic accept;

  assign accept         = start && (!busy || halfSel == LAST);
  assign strobe.capture = accept;
  assign strobe.emit    = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      halfSel <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      halfSel <= '0;
    end else if (busy) begin
      if (halfSel == LAST) begin
        busy    <= 1'b0;
        halfSel <= '0;
      end else begin
        halfSel <= halfSel + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dbf_datapath.sv
module dbf_datapath
  import dbf_pkg::*;
#(
  parameter int SW     = 8,
  parameter int TC_W   = 5,
  parameter int ROWS   = 4,
  parameter int LANES  = 2,
  parameter int HALF_W = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dbf_strobe_t             strobe,
  input  logic [HALF_W-1:0]       halfSel,
  input  logic [ROWS*8*SW-1:0]    blkIn,
  input  logic [TC_W-1:0]         tc,
  input  logic [1:0]              bs,
  input  filt_mode_e              mode,
  input  logic                    p1En,
  input  logic                    q1En,
  output logic                    outValid,
  output logic [HALF_W-1:0]       outHalf,
  output logic [LANES*6*SW-1:0]   outRows
);
  localparam int ROW_BITS = 8 * SW;
  localparam int OUT_BITS = 6 * SW;
  localparam int BW       = $clog2(ROWS * ROW_BITS);

  logic [ROWS*ROW_BITS-1:0] blkR;
  logic [TC_W-1:0]          tcR;
  logic [1:0]               bsR;
  filt_mode_e               modeR;
  logic                     p1R, q1R;
  logic [LANES*OUT_BITS-1:0] laneOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkR  <= '0;
      tcR   <= '0;
      bsR   <= '0;
      modeR <= MODE_BYPASS;
      p1R   <= 1'b0;
      q1R   <= 1'b0;
    end else if (strobe.capture) begin
      blkR  <= blkIn;
      tcR   <= tc;
      bsR   <= bs;
      modeR <= mode;
      p1R   <= p1En;
      q1R   <= q1En;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BW-1:0]     base;
    logic [3*SW-1:0]   pF, qF;
    assign base = BW'((int'(halfSel) * LANES + l) * ROW_BITS);
    dbf_row_filter #(.SW(SW), .TC_W(TC_W)) u_row (
      .pIn  (blkR[base +: 4*SW]),
      .qIn  (blkR[base + BW'(4*SW) +: 4*SW]),
      .tc   (tcR),
      .bs   (bsR),
      .mode (modeR),
      .p1En (p1R),
      .q1En (q1R),
      .pOut (pF),
      .qOut (qF)
    );
    assign laneOut[l*OUT_BITS +: OUT_BITS] = {qF, pF};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outHalf  <= '0;
      outRows  <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outHalf <= halfSel;
        outRows <= laneOut;
      end
    end
  end

endmodule

// File: rtl/dbf_sample_filter.sv
module dbf_sample_filter
  import dbf_pkg::*;
#(
  parameter int SW    = 8,
  parameter int TC_W  = 5,
  parameter int ROWS  = 4,
  parameter int LANES = 2,
  localparam int HALVES = ROWS / LANES,
  localparam int HALF_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [ROWS*8*SW-1:0]  blkIn,
  input  logic [TC_W-1:0]       tc,
  input  logic [1:0]            bs,
  input  logic [1:0]            mode,
  input  logic                  p1En,
  input  logic                  q1En,
  output logic                  outValid,
  output logic [HALF_W-1:0]     outHalf,
  output logic [LANES*6*SW-1:0] outRows
);
  dbf_strobe_t       strobe;
  logic [HALF_W-1:0] halfSel;

  dbf_ctrl #(.HALVES(HALVES), .HALF_W(HALF_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobe  (strobe),
    .halfSel (halfSel)
  );

  dbf_datapath #(
    .SW(SW), .TC_W(TC_W), .ROWS(ROWS), .LANES(LANES), .HALF_W(HALF_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .halfSel  (halfSel),
    .blkIn    (blkIn),
    .tc       (tc),
    .bs       (bs),
    .mode     (filt_mode_e'(mode)),
    .p1En     (p1En),
    .q1En     (q1En),
    .outValid (outValid),
    .outHalf  (outHalf),
    .outRows  (outRows)
  );

endmodule

// File: rtl/dbf_sample_filter_chk.sv
module dbf_sample_filter_chk #(
  parameter int SW     = 8,
  parameter int TC_W   = 5,
  parameter int ROWS   = 4,
  parameter int LANES  = 2,
  parameter int HALF_W = 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic [ROWS*8*SW-1:0]  blkIn,
  input logic [TC_W-1:0]       tc,
  input logic [1:0]            mode,
  input logic                  outValid,
  input logic [HALF_W-1:0]     outHalf,
  input logic [LANES*6*SW-1:0] outRows
);
  logic unusedBits;
  assign unusedBits = ^blkIn;

  // R2: the first beat is always followed by the second
  assert_half_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHalf == '0) |=> (outValid && outHalf != '0));

  // R2: a first beat only ever follows a start two edges earlier
  assert_start_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHalf == '0) |-> $past(start, 2));

  // R10: outputs hold while no beat is presented
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outRows) && $stable(outHalf)));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar j = 0; j < 6; j++) begin : g_smp
      localparam int K  = (j < 3) ? j : j + 1;
      localparam int O  = (l * 6 + j) * SW;
      localparam int I0 = (l * 8 + K) * SW;
      localparam int I1 = ((LANES + l) * 8 + K) * SW;

      // R6: no sample moves further than 2*tc, first beat
      assert_max_shift_lo_R6: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && outHalf == '0) |->
          ((int'(outRows[O +: SW]) - int'($past(blkIn[I0 +: SW], 2)) <=  2 * int'($past(tc, 2))) &&
           (int'(outRows[O +: SW]) - int'($past(blkIn[I0 +: SW], 2)) >= -2 * int'($past(tc, 2)))));

      // R6: same bound, second beat
      assert_max_shift_hi_R6: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && outHalf != '0) |->
          ((int'(outRows[O +: SW]) - int'($past(blkIn[I1 +: SW], 3)) <=  2 * int'($past(tc, 3))) &&
           (int'(outRows[O +: SW]) - int'($past(blkIn[I1 +: SW], 3)) >= -2 * int'($past(tc, 3)))));

      if (j == 2 || j == 5) begin : g_outer
        // R8: third samples change only in strong mode
        assert_outer_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
          (outValid && outHalf == '0 && $past(mode, 2) != 2'd2) |->
            (outRows[O +: SW] == $past(blkIn[I0 +: SW], 2)));
      end
    end
  end

endmodule

bind dbf_sample_filter dbf_sample_filter_chk #(
  .SW(SW), .TC_W(TC_W), .ROWS(ROWS), .LANES(LANES), .HALF_W(HALF_W)
) u_chk (.*);

// File: tb/tb_dbf_sample_filter.sv
`timescale 1ns/1ps
module tb_dbf_sample_filter;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [255:0] blkIn = '0;
  logic [4:0]   tc = '0;
  logic [1:0]   bs = '0;
  logic [1:0]   mode = '0;
  logic         p1En = 1'b0;
  logic         q1En = 1'b0;
  logic         outValid;
  logic [0:0]   outHalf;
  logic [95:0]  outRows;

  always #2.5 clk = ~clk;

  dbf_sample_filter dut (
    .clk(clk), .rstN(rstN), .start(start), .blkIn(blkIn), .tc(tc), .bs(bs),
    .mode(mode), .p1En(p1En), .q1En(q1En),
    .outValid(outValid), .outHalf(outHalf), .outRows(outRows)
  );

  int checks = 0;
  int fails  = 0;
  int aP [4][4];
  int aQ [4][4];
  int bP [4][4];
  int bQ [4][4];
  int cfg [5];
  logic [95:0] lastHalf0;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int clip3(input int lo, input int hi, input int x);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  function automatic int sat8(input int x);
    return clip3(0, 255, x);
  endfunction

  task automatic modelRow(input int p0, p1, p2, p3, q0, q1, q2, q3,
                          output int o0, o1, o2, o3, o4, o5);
    int tcv, d0r, d0, dp, dq, dc;
    tcv = cfg[0];
    o0 = p0; o1 = p1; o2 = p2; o3 = q0; o4 = q1; o5 = q2;
    d0r = (9 * (q0 - p0) - 3 * (q1 - p1) + 8) >>> 4;
    if (cfg[2] == 1 && cfg[1] != 0) begin
      if ((d0r < 0 ? -d0r : d0r) < 10 * tcv) begin
        d0 = clip3(-tcv, tcv, d0r);
        o0 = sat8(p0 + d0);
        o3 = sat8(q0 - d0);
        dp = clip3(-(tcv >>> 1), tcv >>> 1, ((((p2 + p0 + 1) >>> 1) - p1 + d0) >>> 1));
        dq = clip3(-(tcv >>> 1), tcv >>> 1, ((((q2 + q0 + 1) >>> 1) - q1 - d0) >>> 1));
        if (cfg[3] != 0) o1 = sat8(p1 + dp);
        if (cfg[4] != 0) o4 = sat8(q1 - dq);
      end
    end else if (cfg[2] == 2 && cfg[1] != 0) begin
      o0 = clip3(p0 - 2*tcv, p0 + 2*tcv, (p2 + 2*p1 + 2*p0 + 2*q0 + q1 + 4) >>> 3);
      o1 = clip3(p1 - 2*tcv, p1 + 2*tcv, (p2 + p1 + p0 + q0 + 2) >>> 2);
      o2 = clip3(p2 - 2*tcv, p2 + 2*tcv, (2*p3 + 3*p2 + p1 + p0 + q0 + 4) >>> 3);
      o3 = clip3(q0 - 2*tcv, q0 + 2*tcv, (q2 + 2*q1 + 2*q0 + 2*p0 + p1 + 4) >>> 3);
      o4 = clip3(q1 - 2*tcv, q1 + 2*tcv, (q2 + q1 + q0 + p0 + 2) >>> 2);
      o5 = clip3(q2 - 2*tcv, q2 + 2*tcv, (2*q3 + 3*q2 + q1 + q0 + p0 + 4) >>> 3);
    end else if (cfg[2] == 3 && cfg[1] == 2) begin
      dc = clip3(-tcv, tcv, (4 * (q0 - p0) + p1 - q1 + 4) >>> 3);
      o0 = sat8(p0 + dc);
      o3 = sat8(q0 - dc);
    end
  endtask

  function automatic logic [255:0] packBlk(input bit useB);
    logic [255:0] v;
    v = '0;
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) begin
        v[(r*8+k)*8 +: 8]   = 8'(useB ? bP[r][k] : aP[r][k]);
        v[(r*8+k+4)*8 +: 8] = 8'(useB ? bQ[r][k] : aQ[r][k]);
      end
    return v;
  endfunction

  task automatic setCfg(input int tcv, bsv, modev, p1e, q1e);
    cfg[0] = tcv; cfg[1] = bsv; cfg[2] = modev; cfg[3] = p1e; cfg[4] = q1e;
  endtask

  task automatic driveStart(input bit useB);
    blkIn = packBlk(useB);
    tc    = 5'(cfg[0]);
    bs    = 2'(cfg[1]);
    mode  = 2'(cfg[2]);
    p1En  = cfg[3][0];
    q1En  = cfg[4][0];
    start = 1'b1;
  endtask

  task automatic checkHalf(input string req, input int h, input bit useB);
    int e [6];
    check({req, " valid"}, int'(outValid), 1);
    check({req, " half"}, int'(outHalf), h);
    for (int l = 0; l < 2; l++) begin
      int r;
      r = h * 2 + l;
      if (useB)
        modelRow(bP[r][0], bP[r][1], bP[r][2], bP[r][3], bQ[r][0], bQ[r][1], bQ[r][2], bQ[r][3],
                 e[0], e[1], e[2], e[3], e[4], e[5]);
      else
        modelRow(aP[r][0], aP[r][1], aP[r][2], aP[r][3], aQ[r][0], aQ[r][1], aQ[r][2], aQ[r][3],
                 e[0], e[1], e[2], e[3], e[4], e[5]);
      for (int j = 0; j < 6; j++)
        check($sformatf("%s row%0d s%0d", req, r, j), int'(outRows[(l*6+j)*8 +: 8]), e[j]);
    end
    if (h == 0) lastHalf0 = outRows;
  endtask

  task automatic runBlock(input string req);
    @(negedge clk); driveStart(1'b0);
    @(negedge clk); start = 1'b0;
    @(negedge clk); checkHalf(req, 0, 1'b0);
    @(negedge clk); checkHalf(req, 1, 1'b0);
  endtask

  task automatic fillSmooth();
    for (int r = 0; r < 4; r++) begin
      aP[r][0] = 100 + 3*r; aP[r][1] = 97 + r; aP[r][2] = 95; aP[r][3] = 94;
      aQ[r][0] = 112 - r;   aQ[r][1] = 115;    aQ[r][2] = 117 + r; aQ[r][3] = 118;
    end
  endtask

  task automatic testReset();
    check("R1 valid in reset", int'(outValid), 0);
    check("R1 rows in reset", int'(outRows == '0), 1);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(outValid), 0);
    check("R1 half after reset", int'(outHalf), 0);
    check("R1 rows after reset", int'(outRows == '0), 1);
  endtask

  task automatic testNormal();
    fillSmooth(); setCfg(4, 1, 1, 1, 1); runBlock("R3 R4 normal both");
    setCfg(4, 1, 1, 0, 0); runBlock("R4 normal no enables");
    check("R4 p1 kept", int'(lastHalf0[15:8]), aP[0][1]);
    check("R4 q1 kept", int'(lastHalf0[39:32]), aQ[0][1]);
    setCfg(4, 1, 1, 1, 0); runBlock("R4 normal p side only");
  endtask

  task automatic testVeto();
    fillSmooth();
    for (int r = 0; r < 4; r += 2) begin
      aP[r][0] = 50; aP[r][1] = 50; aP[r][2] = 50; aP[r][3] = 50;
      aQ[r][0] = 200; aQ[r][1] = 200; aQ[r][2] = 200; aQ[r][3] = 200;
    end
    setCfg(2, 2, 1, 1, 1); runBlock("R5 veto");
    check("R5 vetoed p0 kept", int'(lastHalf0[7:0]), 50);
    check("R5 vetoed q0 kept", int'(lastHalf0[31:24]), 200);
  endtask

  task automatic testStrong();
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) begin
        aP[r][k] = 100 + r; aQ[r][k] = 140 - k;
      end
    setCfg(3, 1, 2, 0, 0); runBlock("R6 strong clipped");
    check("R6 p0 clipped to p0+2tc", int'(lastHalf0[7:0]), 106);
    fillSmooth(); setCfg(20, 2, 2, 0, 0); runBlock("R6 strong wide tc");
  endtask

  task automatic testChroma();
    fillSmooth(); setCfg(3, 2, 3, 0, 0); runBlock("R7 chroma bs2");
    setCfg(3, 1, 3, 1, 1); runBlock("R7 R8 chroma bs1 unchanged");
    check("R8 chroma bs1 p0 kept", int'(lastHalf0[7:0]), aP[0][0]);
  endtask

  task automatic testBypass();
    fillSmooth(); setCfg(8, 2, 0, 1, 1); runBlock("R8 mode none");
    setCfg(8, 0, 1, 1, 1); runBlock("R8 normal bs0");
    check("R8 normal bs0 q0 kept", int'(lastHalf0[31:24]), aQ[0][0]);
    setCfg(8, 0, 2, 0, 0); runBlock("R8 strong bs0");
  endtask

  task automatic testSaturate();
    fillSmooth();
    aP[0][0] = 254; aP[0][1] = 255; aP[0][2] = 250; aQ[0][0] = 255; aQ[0][1] = 0; aQ[0][2] = 10;
    aP[1][0] = 1;   aP[1][1] = 0;   aP[1][2] = 5;   aQ[1][0] = 0;   aQ[1][1] = 255; aQ[1][2] = 240;
    setCfg(20, 1, 1, 0, 0); runBlock("R3 saturation");
    check("R3 p0 saturates high", int'(lastHalf0[7:0]), 255);
    check("R3 q0 row0", int'(lastHalf0[31:24]), 235);
    check("R3 p0 saturates low", int'(lastHalf0[55:48]), 0);
    check("R3 q0 row1", int'(lastHalf0[79:72]), 20);
  endtask

  task automatic testIgnore();
    logic [95:0] held;
    fillSmooth(); setCfg(4, 1, 1, 1, 1);
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) begin
        bP[r][k] = 30 + k; bQ[r][k] = 60 + r;
      end
    @(negedge clk); driveStart(1'b0);
    @(negedge clk); driveStart(1'b1);
    @(negedge clk); start = 1'b0; checkHalf("R9 ignored start beat0", 0, 1'b0);
    @(negedge clk); checkHalf("R9 ignored start beat1", 1, 1'b0);
    held = outRows;
    @(negedge clk); check("R9 no extra beat", int'(outValid), 0);
    check("R10 rows held", int'(outRows == held), 1);
    check("R10 half held", int'(outHalf), 1);
    @(negedge clk); check("R10 rows still held", int'(outRows == held), 1);
  endtask

  task automatic testBackToBack();
    fillSmooth(); setCfg(4, 1, 1, 1, 1);
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) begin
        bP[r][k] = 120 + r; bQ[r][k] = 128 + k;
      end
    @(negedge clk); driveStart(1'b0);
    @(negedge clk); start = 1'b0;
    @(negedge clk); checkHalf("R2 first edge beat0", 0, 1'b0); driveStart(1'b1);
    @(negedge clk); checkHalf("R2 first edge beat1", 1, 1'b0); start = 1'b0;
    @(negedge clk); checkHalf("R2 second edge beat0", 0, 1'b1);
    @(negedge clk); checkHalf("R2 second edge beat1", 1, 1'b1);
    @(negedge clk); check("R2 idle after pair", int'(outValid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testNormal();
    testVeto();
    testStrong();
    testChroma();
    testBypass();
    testSaturate();
    testIgnore();
    testBackToBack();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule